// File: doc/BRIEF.md
# Three-Wire Host to Four-Way Open-Drain I2C Switch

This block lets a single host I2C master reach one of four downstream open-drain I2C buses. The host side uses three separate wires: an SDA input, an SCL input and an SDA output. The downstream buses are an SFP cage, a mezzanine card and two optical modules. A 2-bit code from the host picks the downstream bus that is active. Only that bus sees the host clock and the host's data-low. The other buses stay released.

The data line sent back to the host is the wired-AND of all four downstream SDA lines. A slave answering on the active bus therefore reaches the master, and so does any device that holds its line low. The same select code also drives the active-low module-select strobes of the two optical modules, so each module only listens while its own bus is chosen.

Each downstream line is represented by a drive-low enable. The line level is read back as an input. All outputs are registered and follow the sampled inputs by one clock. A new select code only takes effect on a cycle where the host SDA and SCL are both high. A code change in the middle of a transfer therefore cannot pull a newly chosen bus low.

Top module: `i2c_fanout_mux`

## Requirements
- R1: Bus index i is chosen by select code i: code 0 is the SFP bus (index 0), code 1 is the mezzanine bus (index 1), code 2 is optical module A (index 2) and code 3 is optical module B (index 3). Bit i of every per-bus vector belongs to bus index i.
- R2: One clock after host SDA-in is sampled low, `dev_sda_oe` has exactly the bit of the active bus set (1 = drive low). One clock after host SDA-in is sampled high, `dev_sda_oe` is all zero.
- R3: One clock after host SCL-in is sampled low, `dev_scl_oe` has exactly the bit of the active bus set. One clock after host SCL-in is sampled high, `dev_scl_oe` is all zero. An unselected bus never has its SCL driven.
- R4: One clock after sampling, `host_sda_out` equals the AND of all four `dev_sda_in` line levels.
- R5: `mod_sel_n[0]` (optical module A) is low exactly while the active code is 2. `mod_sel_n[1]` (optical module B) is low exactly while the active code is 3. Both are registered with the same one-clock latency.
- R6: The active code is loaded from `host_sel` only on a clock where host SDA-in and SCL-in are both sampled high. On any other clock the previous active code is kept, whatever `host_sel` does.
- R7: At most one bit of `dev_sda_oe` and at most one bit of `dev_scl_oe` is set in any cycle.
- R8: A synchronous active-high reset clears both enable vectors, sets `host_sda_out` high and `mod_sel_n` to 2'b11, and makes code 0 the active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sda_in | input | 1 | Data level driven by the host master |
| host_scl_in | input | 1 | Clock level driven by the host master |
| host_sel | input | 2 | Requested downstream bus code |
| host_sda_out | output | 1 | Wired-AND of downstream data lines, sent back to the host |
| dev_sda_in | input | 4 | Sensed level of each downstream SDA line |
| dev_sda_oe | output | 4 | Drive-low enable for each downstream SDA line |
| dev_scl_oe | output | 4 | Drive-low enable for each downstream SCL line |
| mod_sel_n | output | 2 | Active-low module selects, bit 0 module A, bit 1 module B |

## Verification
The properties assume that all inputs are synchronous to the clock and hold known values. They also assume that `dev_sda_in` reflects the pull-up resolved with this block's own enables and with any device that pulls low. The stimulus meets this by deriving each line in the bench from the enables and a per-bus device pull. It changes inputs only on the falling edge and holds every pattern long enough for the drive and return path to settle, which takes two clocks. Select changes are issued both inside and outside the idle condition, so the hold rule is exercised against these same assumptions.

// File: rtl/i2c_fanout_pkg.sv
package i2c_fanout_pkg;
  localparam int unsigned BUS_COUNT  = 4;
  localparam int unsigned CODE_W     = $clog2(BUS_COUNT);
  localparam int unsigned OPT_FIRST  = 2;
  localparam int unsigned OPT_COUNT  = 2;

  typedef logic [CODE_W-1:0] bus_code_t;

  localparam bus_code_t RESET_CODE = '0;
endpackage

// File: rtl/i2c_fanout_sel_hold.sv
module i2c_fanout_sel_hold #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic [CODE_W-1:0] sel_req,
  output logic [CODE_W-1:0] sel_next
);
  logic [CODE_W-1:0] sel_q;
  logic              bus_idle;

  // Loading is allowed only while both host wires are high.
  assign bus_idle = sda_in & scl_in;
  assign sel_next = bus_idle ? sel_req : sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_next;
  end
endmodule

// File: rtl/i2c_fanout_lane.sv
module i2c_fanout_lane (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic sda_in,
  input  logic scl_in,
  output logic sda_oe,
  output logic scl_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      sda_oe <= hit & ~sda_in;
      scl_oe <= hit & ~scl_in;
    end
  end
endmodule

// File: rtl/i2c_fanout_merge.sv
module i2c_fanout_merge #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lines,
  output logic             merged
);
  always_ff @(posedge clk) begin
    if (rst) merged <= 1'b1;
    else     merged <= &lines;
  end
endmodule

// File: rtl/i2c_fanout_mux.sv
module i2c_fanout_mux
  import i2c_fanout_pkg::*;
#(
  parameter int unsigned N_BUS   = BUS_COUNT,
  parameter int unsigned N_OPT   = OPT_COUNT,
  parameter int unsigned OPT_LOW = OPT_FIRST
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_sda_in,
  input  logic                     host_scl_in,
  input  logic [$clog2(N_BUS)-1:0] host_sel,
  output logic                     host_sda_out,
  input  logic [N_BUS-1:0]         dev_sda_in,
  output logic [N_BUS-1:0]         dev_sda_oe,
  output logic [N_BUS-1:0]         dev_scl_oe,
  output logic [N_OPT-1:0]         mod_sel_n
);
  localparam int unsigned SW = $clog2(N_BUS);

  logic [SW-1:0] sel_next;

  i2c_fanout_sel_hold #(.CODE_W(SW)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .sda_in  (host_sda_in),
    .scl_in  (host_scl_in),
    .sel_req (host_sel),
    .sel_next(sel_next)
  );

  for (genvar gi = 0; gi < N_BUS; gi++) begin : g_lane
    logic lane_hit;
    assign lane_hit = (sel_next == SW'(gi));
    i2c_fanout_lane u_lane (
      .clk   (clk),
      .rst   (rst),
      .hit   (lane_hit),
      .sda_in(host_sda_in),
      .scl_in(host_scl_in),
      .sda_oe(dev_sda_oe[gi]),
      .scl_oe(dev_scl_oe[gi])
    );
  end

  i2c_fanout_merge #(.WIDTH(N_BUS)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .lines (dev_sda_in),
    .merged(host_sda_out)
  );

  for (genvar gj = 0; gj < N_OPT; gj++) begin : g_msel
    always_ff @(posedge clk) begin
      if (rst) mod_sel_n[gj] <= 1'b1;
      else     mod_sel_n[gj] <= (sel_next != SW'(OPT_LOW + gj));
    end
  end
endmodule

// File: rtl/i2c_fanout_mux_chk.sv
module i2c_fanout_mux_chk #(
  parameter int unsigned N_BUS = 4,
  parameter int unsigned N_OPT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             host_sda_in,
  input logic             host_scl_in,
  input logic             host_sda_out,
  input logic [N_BUS-1:0] dev_sda_in,
  input logic [N_BUS-1:0] dev_sda_oe,
  input logic [N_BUS-1:0] dev_scl_oe,
  input logic [N_OPT-1:0] mod_sel_n
);
  assert_sda_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_sda_oe));
  assert_scl_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_scl_oe));
  assert_sda_release_R2: assert property (@(posedge clk) disable iff (rst)
    host_sda_in |=> (dev_sda_oe == '0));
  assert_sda_drive_R2: assert property (@(posedge clk) disable iff (rst)
    !host_sda_in |=> (|dev_sda_oe));
  assert_scl_release_R3: assert property (@(posedge clk) disable iff (rst)
    host_scl_in |=> (dev_scl_oe == '0));
  assert_scl_drive_R3: assert property (@(posedge clk) disable iff (rst)
    !host_scl_in |=> (|dev_scl_oe));
  assert_merge_high_R4: assert property (@(posedge clk) disable iff (rst)
    (&dev_sda_in) |=> host_sda_out);
  assert_merge_low_R4: assert property (@(posedge clk) disable iff (rst)
    !(&dev_sda_in) |=> !host_sda_out);
  assert_msel_single_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(~mod_sel_n) <= 1);
  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(host_sda_in && host_scl_in) |=> $stable(mod_sel_n));
endmodule

bind i2c_fanout_mux i2c_fanout_mux_chk #(.N_BUS(N_BUS), .N_OPT(N_OPT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_sda_in (host_sda_in),
  .host_scl_in (host_scl_in),
  .host_sda_out(host_sda_out),
  .dev_sda_in  (dev_sda_in),
  .dev_sda_oe  (dev_sda_oe),
  .dev_scl_oe  (dev_scl_oe),
  .mod_sel_n   (mod_sel_n)
);

// File: tb/i2c_fanout_mux_bench.sv
module i2c_fanout_mux_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sda = 1'b1;
  logic       scl = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [3:0] ext_low = 4'd0;
  logic       sda_out;
  logic [3:0] line_sda;
  logic [3:0] sda_oe;
  logic [3:0] scl_oe;
  logic [1:0] msel_n;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  // Pull-up resolved with the block's drivers and device pulls.
  assign line_sda = ~(sda_oe | ext_low);

  i2c_fanout_mux u_i2c_fanout_mux (
    .clk(clk), .rst(rst), .host_sda_in(sda), .host_scl_in(scl),
    .host_sel(sel), .host_sda_out(sda_out), .dev_sda_in(line_sda),
    .dev_sda_oe(sda_oe), .dev_scl_oe(scl_oe), .mod_sel_n(msel_n)
  );

  // {sel, sda, scl, ext_low, exp sda_oe, exp scl_oe, exp out, exp msel_n}
  localparam logic [18:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b1, 4'b0000, 4'b0001, 4'b0000, 1'b0, 2'b11},
    {2'd1, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0010, 1'b1, 2'b11},
    {2'd2, 1'b0, 1'b0, 4'b0000, 4'b0100, 4'b0100, 1'b0, 2'b10},
    {2'd3, 1'b0, 1'b0, 4'b0000, 4'b1000, 4'b1000, 1'b0, 2'b01},
    {2'd3, 1'b1, 1'b1, 4'b0001, 4'b0000, 4'b0000, 1'b0, 2'b01},
    {2'd2, 1'b1, 1'b0, 4'b1000, 4'b0000, 4'b0100, 1'b0, 2'b10},
    {2'd1, 1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'b11},
    {2'd0, 1'b0, 1'b1, 4'b0100, 4'b0001, 4'b0000, 1'b0, 2'b11}
  };

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [10:0] got,
                       input logic [10:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got sda_oe/scl_oe/out/msel=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [10:0] obs();
    return {sda_oe, scl_oe, sda_out, msel_n};
  endfunction

  initial begin
    @(negedge clk);
    tick(3);
    // R8: reset values
    check("R8", obs(), {4'b0000, 4'b0000, 1'b1, 2'b11});
    rst = 1'b0;
    tick(1);

    // R1 R2 R3 R4 R5: table walk
    for (int v = 0; v < 8; v++) begin
      sel = VEC[v][18:17]; sda = 1'b1; scl = 1'b1; ext_low = 4'd0;
      tick(2);
      sda = VEC[v][16]; scl = VEC[v][15]; ext_low = VEC[v][14:11];
      tick(3);
      check("R1/R2/R3/R4/R5", obs(), VEC[v][10:0]);
    end

    // R6: code change while SDA low is held off
    sda = 1'b1; scl = 1'b1; ext_low = 4'd0; sel = 2'd2;
    tick(2);
    sda = 1'b0;
    tick(2);
    sel = 2'd3;
    tick(3);
    check("R6 held during low SDA", obs(), {4'b0100, 4'b0000, 1'b0, 2'b10});
    sda = 1'b1;
    tick(2);
    check("R6 applied when idle", obs(), {4'b0000, 4'b0000, 1'b1, 2'b01});
    sda = 1'b0;
    tick(2);
    check("R6 new bus driven", obs(), {4'b1000, 4'b0000, 1'b0, 2'b01});

    // R6: SCL low alone also blocks loading
    sda = 1'b1; scl = 1'b0; sel = 2'd1;
    tick(3);
    check("R6 held during low SCL", obs(), {4'b0000, 4'b1000, 1'b1, 2'b01});
    scl = 1'b1;
    tick(2);
    check("R6 applied after SCL high", obs(), {4'b0000, 4'b0000, 1'b1, 2'b11});
    scl = 1'b0;
    tick(2);
    check("R3 mezzanine clock", obs(), {4'b0000, 4'b0010, 1'b1, 2'b11});

    // R4: a device on an unselected bus pulls its line low
    scl = 1'b1; ext_low = 4'b0010 << 1;
    tick(2);
    check("R4 foreign low", obs(), {4'b0000, 4'b0000, 1'b0, 2'b11});
    ext_low = 4'd0;

    // R8: reset in mid-transfer, then low SDA before any idle cycle
    sel = 2'd3; sda = 1'b0;
    tick(2);
    rst = 1'b1;
    tick(1);
    check("R8 mid-run reset", obs(), {4'b0000, 4'b0000, 1'b1, 2'b11});
    rst = 1'b0;
    tick(3);
    check("R8 code 0 after reset", obs(), {4'b0001, 4'b0000, 1'b0, 2'b11});
    sda = 1'b1;
    tick(3);
    // R7: a single enable bit is seen whenever any bit is set
    check("R7 select 3 idle", obs(), {4'b0000, 4'b0000, 1'b1, 2'b01});
    sda = 1'b0; scl = 1'b0;
    tick(2);
    n_run++;
    if ($countones(sda_oe) != 1 || $countones(scl_oe) != 1) begin
      n_fail++;
      $display("FAIL R7: got sda_oe=%b scl_oe=%b expected one bit each", sda_oe, scl_oe);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule